// File: doc/BRIEF.md
# TDM Bus Channel Extractor

This block takes a serial time-division multiplexed stream (a sample clock, a one-cycle frame sync and one data bit per clock) and picks three channels out of it. Two bearer channels are eight bits wide and each occupies one whole byte slot. One signalling channel is two bits wide and sits in one of the four two-bit groups of a chosen byte slot. A frame is 64 byte slots of eight bits, so it lasts 512 clocks. Bits arrive most significant first.

The host writes a slot number for each channel through three simple write ports. A write lands in a shadow register. The shadow is copied into the working selection only when a new frame begins, so a capture never switches slot part-way through a frame. Each channel has a capture stage that shifts in the bits of its window. When the last bit of that window has been sampled, the stage updates its output and raises a valid strobe for one cycle. Capture happens only while the multiplexed bus format is enabled, and only after the first frame sync since reset has located the frame.

Top module: `tdm_chan_extract`

## Requirements
- R1: Data is sampled on each rising clock edge. A bearer channel assigned to slot s takes frame positions 8s to 8s+7, and the first bit received ends up in bit 7 of its output byte.
- R2: The signalling selection byte holds the byte slot in bits 7:2 and the sub-slot in bits 1:0. Sub-slot k covers positions 8s+2k and 8s+2k+1, so sub-slot 0 is the first pair received and sub-slot 3 is the last. The first bit of the pair lands in `d_dibit[1]`.
- R3: A written selection takes effect at the first frame start after the write edge. A write in the same cycle as a frame start waits for the frame after that. The selection never changes mid-frame.
- R4: After reset the selections are bearer 1 at slot 0, bearer 2 at slot 1 and signalling 08h (slot 2, sub-slot 0). All outputs are zero and all strobes are low.
- R5: While `mux_en` is low at the cycle a window's last bit is sampled, that channel's output holds its value and its strobe stays low.
- R6: The output value and a one-cycle strobe both appear on the clock edge that samples the window's last bit. The value then holds until the next capture.
- R7: A frame sync marks its own sample as slot 0 bit 0, and this also applies to an early sync. Without a sync the position wraps from 511 to 0.
- R8: Nothing is captured before the first frame sync after reset.
- R9: Channels given the same slot each capture the same bits independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_en | input | 1 | Multiplexed bus format enable |
| fsync | input | 1 | Frame sync, high with slot 0 bit 0 |
| sdata | input | 1 | Serial data |
| wr_b1 | input | 1 | Write strobe, bearer 1 selection |
| wr_b1_data | input | 6 | Bearer 1 slot number |
| wr_b2 | input | 1 | Write strobe, bearer 2 selection |
| wr_b2_data | input | 6 | Bearer 2 slot number |
| wr_d | input | 1 | Write strobe, signalling selection |
| wr_d_data | input | 8 | Signalling slot (7:2) and sub-slot (1:0) |
| b1_byte | output | 8 | Captured bearer 1 byte |
| b1_vld | output | 1 | Bearer 1 capture strobe |
| b2_byte | output | 8 | Captured bearer 2 byte |
| b2_vld | output | 1 | Bearer 2 capture strobe |
| d_dibit | output | 2 | Captured signalling pair |
| d_vld | output | 1 | Signalling capture strobe |

## Verification
Each result is registered once. The value and strobe for a window show up one clock after its last bit is driven, and a selection write first matters at the first frame start after the write edge. The bench drives inputs on falling edges and keeps its own position count, a record of the bits of the current frame and its own shadow and working selections. At each falling edge it compares all six outputs with the expectation it formed for the rising edge just past. This means the value, the strobe and the hold behaviour are all checked in the exact cycle they are due.

// File: rtl/tdm_ext_pkg.sv
package tdm_ext_pkg;

  // First bit index of a capture window inside a byte slot.
  function automatic int win_first(int sub, int width);
    return sub * width;
  endfunction

  // Last bit index of a capture window inside a byte slot.
  function automatic int win_last(int sub, int width);
    return sub * width + width - 1;
  endfunction

  // Frame position of the last bit of a window.
  function automatic int win_end_pos(int slot, int sub, int width, int slot_bits);
    return slot * slot_bits + win_last(sub, width);
  endfunction

endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_BITS = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic [SW-1:0] cur_slot,
  output logic [BW-1:0] cur_bit,
  output logic          frame_start,
  output logic          aligned
);
  localparam int PW = SW + BW;
  localparam logic [PW-1:0] LAST_POS = PW'(NUM_SLOTS * SLOT_BITS - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_cur;
  logic          aligned_q;

  // Position of the bit being sampled at this edge.
  assign pos_cur     = fsync ? '0 : pos_q;
  assign cur_slot    = pos_cur[PW-1:BW];
  assign cur_bit     = pos_cur[BW-1:0];
  assign frame_start = (pos_cur == '0);
  assign aligned     = aligned_q | fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else begin
      pos_q     <= (pos_cur == LAST_POS) ? '0 : pos_cur + 1'b1;
      aligned_q <= aligned_q | fsync;
    end
  end
endmodule

// File: rtl/tdm_sel_reg.sv
module tdm_sel_reg #(
  parameter int W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         frame_start,
  output logic [W-1:0] active,
  output logic [W-1:0] eff
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  // At a frame start the pending shadow already governs that first sample.
  assign eff    = frame_start ? shadow_q : active_q;
  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      if (wr) shadow_q <= wr_data;
      active_q <= eff;
    end
  end
endmodule

// File: rtl/tdm_chan_cap.sv
module tdm_chan_cap
  import tdm_ext_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_BITS = 8,
  parameter int WIDTH     = 8,
  parameter int SUBW      = 2,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SW-1:0]    cur_slot,
  input  logic [BW-1:0]    cur_bit,
  input  logic [SW-1:0]    sel_slot,
  input  logic [SUBW-1:0]  sel_sub,
  input  logic             sdata,
  output logic [WIDTH-1:0] val,
  output logic             vld
);
  logic [BW-1:0]    first_b;
  logic [BW-1:0]    last_b;
  logic             in_win;
  logic             at_end;
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] sh_next;
  logic [WIDTH-1:0] val_q;
  logic             vld_q;

  assign first_b = BW'(win_first(int'(sel_sub), WIDTH));
  assign last_b  = BW'(win_last(int'(sel_sub), WIDTH));
  assign in_win  = (cur_slot == sel_slot) && (cur_bit >= first_b) && (cur_bit <= last_b);
  assign at_end  = in_win && (cur_bit == last_b);

  generate
    if (WIDTH > 1) begin : g_multi
      assign sh_next = {sh_q[WIDTH-2:0], sdata};
    end else begin : g_single
      assign sh_next = sdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (in_win) sh_q <= sh_next;
      vld_q <= at_end && en;
      if (at_end && en) val_q <= sh_next;
    end
  end

  assign val = val_q;
  assign vld = vld_q;
endmodule

// File: rtl/tdm_chan_extract.sv
module tdm_chan_extract #(
  parameter int NUM_SLOTS  = 64,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_BITS   = 2,
  parameter int RST_B1     = 0,
  parameter int RST_B2     = 1,
  parameter int RST_D_SLOT = 2,
  parameter int RST_D_SUB  = 0,
  localparam int SW   = $clog2(NUM_SLOTS),
  localparam int SUBW = $clog2(SLOT_BITS / SIG_BITS),
  localparam int DW   = SW + SUBW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mux_en,
  input  logic                 fsync,
  input  logic                 sdata,
  input  logic                 wr_b1,
  input  logic [SW-1:0]        wr_b1_data,
  input  logic                 wr_b2,
  input  logic [SW-1:0]        wr_b2_data,
  input  logic                 wr_d,
  input  logic [DW-1:0]        wr_d_data,
  output logic [SLOT_BITS-1:0] b1_byte,
  output logic                 b1_vld,
  output logic [SLOT_BITS-1:0] b2_byte,
  output logic                 b2_vld,
  output logic [SIG_BITS-1:0]  d_dibit,
  output logic                 d_vld
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam logic [DW-1:0] RST_D = {SW'(RST_D_SLOT), SUBW'(RST_D_SUB)};

  logic [SW-1:0] cur_slot;
  logic [BW-1:0] cur_bit;
  logic          frame_start;
  logic          aligned;
  logic          cap_en;
  logic [SW-1:0] act_b1, eff_b1;
  logic [SW-1:0] act_b2, eff_b2;
  logic [DW-1:0] act_d, eff_d;

  assign cap_en = mux_en && aligned;

  tdm_pos_counter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .cur_slot(cur_slot), .cur_bit(cur_bit),
    .frame_start(frame_start), .aligned(aligned)
  );

  tdm_sel_reg #(.W(SW), .RST_VAL(SW'(RST_B1))) u_sel_b1 (
    .clk(clk), .rst_n(rst_n), .wr(wr_b1), .wr_data(wr_b1_data),
    .frame_start(frame_start), .active(act_b1), .eff(eff_b1)
  );

  tdm_sel_reg #(.W(SW), .RST_VAL(SW'(RST_B2))) u_sel_b2 (
    .clk(clk), .rst_n(rst_n), .wr(wr_b2), .wr_data(wr_b2_data),
    .frame_start(frame_start), .active(act_b2), .eff(eff_b2)
  );

  tdm_sel_reg #(.W(DW), .RST_VAL(RST_D)) u_sel_d (
    .clk(clk), .rst_n(rst_n), .wr(wr_d), .wr_data(wr_d_data),
    .frame_start(frame_start), .active(act_d), .eff(eff_d)
  );

  tdm_chan_cap #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .WIDTH(SLOT_BITS), .SUBW(1)) u_cap_b1 (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .sel_slot(eff_b1), .sel_sub(1'b0), .sdata(sdata), .val(b1_byte), .vld(b1_vld)
  );

  tdm_chan_cap #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .WIDTH(SLOT_BITS), .SUBW(1)) u_cap_b2 (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .sel_slot(eff_b2), .sel_sub(1'b0), .sdata(sdata), .val(b2_byte), .vld(b2_vld)
  );

  tdm_chan_cap #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .WIDTH(SIG_BITS), .SUBW(SUBW)) u_cap_d (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .sel_slot(eff_d[DW-1:SUBW]), .sel_sub(eff_d[SUBW-1:0]), .sdata(sdata),
    .val(d_dibit), .vld(d_vld)
  );
endmodule

// File: rtl/tdm_chan_extract_chk.sv
module tdm_chan_extract_chk #(
  parameter int SW = 6,
  parameter int BW = 3,
  parameter int DW = 8,
  parameter int SLOT_BITS = 8,
  parameter int SIG_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mux_en,
  input logic                 fsync,
  input logic [SLOT_BITS-1:0] b1_byte,
  input logic                 b1_vld,
  input logic [SLOT_BITS-1:0] b2_byte,
  input logic                 b2_vld,
  input logic [SIG_BITS-1:0]  d_dibit,
  input logic                 d_vld,
  input logic [SW-1:0]        act_b1,
  input logic [SW-1:0]        act_b2,
  input logic [DW-1:0]        act_d,
  input logic                 frame_start,
  input logic                 aligned,
  input logic [SW-1:0]        cur_slot,
  input logic [BW-1:0]        cur_bit
);
  logic any_vld;
  assign any_vld = b1_vld || b2_vld || d_vld;

  p_b1_end_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    b1_vld |-> ($past(cur_bit) == BW'(SLOT_BITS - 1)));

  p_d_end_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |-> $past(cur_bit[0]));

  p_cfg_at_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_b1) || !$stable(act_b2) || !$stable(act_d)) |-> $past(frame_start));

  p_off_no_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |-> $past(mux_en));

  p_b1_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b1_vld |=> !b1_vld);

  p_d_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |=> !d_vld);

  p_b1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(b1_byte) |-> b1_vld);

  p_b2_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(b2_byte) |-> b2_vld);

  p_d_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(d_dibit) |-> d_vld);

  p_sync_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync ##1 !fsync) |-> (cur_slot == '0 && cur_bit == BW'(1)));

  p_no_vld_unaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |-> $past(aligned));
endmodule

bind tdm_chan_extract tdm_chan_extract_chk #(
  .SW(SW), .BW(BW), .DW(DW), .SLOT_BITS(SLOT_BITS), .SIG_BITS(SIG_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_en(mux_en), .fsync(fsync),
  .b1_byte(b1_byte), .b1_vld(b1_vld), .b2_byte(b2_byte), .b2_vld(b2_vld),
  .d_dibit(d_dibit), .d_vld(d_vld),
  .act_b1(act_b1), .act_b2(act_b2), .act_d(act_d),
  .frame_start(frame_start), .aligned(aligned),
  .cur_slot(cur_slot), .cur_bit(cur_bit)
);

// File: tb/test_tdm_chan_extract.sv
module test_tdm_chan_extract;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mux_en = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic       wr_b1 = 1'b0, wr_b2 = 1'b0, wr_d = 1'b0;
  logic [5:0] wr_b1_data = '0, wr_b2_data = '0;
  logic [7:0] wr_d_data = '0;
  logic [7:0] b1_byte, b2_byte;
  logic [1:0] d_dibit;
  logic       b1_vld, b2_vld, d_vld;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R4";

  // Bench reference state
  bit         frame_bits [FRAME];
  int         sh_b1 = 0, sh_b2 = 1, sh_d = 8;
  int         ac_b1 = 0, ac_b2 = 1, ac_d = 8;
  int         pos = 0;
  bit         synced = 1'b0;
  logic [7:0] e_b1 = '0, e_b2 = '0;
  logic [1:0] e_d = '0;
  bit         e_b1v = 1'b0, e_b2v = 1'b0, e_dv = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdm_chan_extract i_tdm_chan_extract (
    .clk(clk), .rst_n(rst_n), .mux_en(mux_en), .fsync(fsync), .sdata(sdata),
    .wr_b1(wr_b1), .wr_b1_data(wr_b1_data), .wr_b2(wr_b2), .wr_b2_data(wr_b2_data),
    .wr_d(wr_d), .wr_d_data(wr_d_data),
    .b1_byte(b1_byte), .b1_vld(b1_vld), .b2_byte(b2_byte), .b2_vld(b2_vld),
    .d_dibit(d_dibit), .d_vld(d_vld)
  );

  // Bearer byte of a slot: earliest bit of the slot is the MSB.
  function automatic logic [7:0] take_byte(int slot);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[7 - i] = frame_bits[slot * 8 + i];
    return r;
  endfunction

  // Signalling pair from a selection byte: slot in 7:2, sub-slot in 1:0.
  function automatic logic [1:0] take_pair(int sel);
    int base = (sel / 4) * 8 + (sel % 4) * 2;
    return {frame_bits[base], frame_bits[base + 1]};
  endfunction

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // One clock: verify the last edge's results, then drive and predict the next edge.
  task automatic cycle(bit fs, bit d, bit en, int wsel, int wval);
    int p;
    bit live;
    @(negedge clk);
    check("b1_vld (R6)", int'(b1_vld), int'(e_b1v));
    check("b2_vld (R6)", int'(b2_vld), int'(e_b2v));
    check("d_vld (R6)", int'(d_vld), int'(e_dv));
    check("b1_byte (R1)", int'(b1_byte), int'(e_b1));
    check("b2_byte (R1)", int'(b2_byte), int'(e_b2));
    check("d_dibit (R2)", int'(d_dibit), int'(e_d));
    fsync = fs; sdata = d; mux_en = en;
    wr_b1 = (wsel == 1); wr_b1_data = 6'(wval);
    wr_b2 = (wsel == 2); wr_b2_data = 6'(wval);
    wr_d  = (wsel == 3); wr_d_data  = 8'(wval);
    p = fs ? 0 : pos;
    if (fs) synced = 1'b1;
    if (p == 0) begin
      ac_b1 = sh_b1; ac_b2 = sh_b2; ac_d = sh_d;
    end
    if (wsel == 1) sh_b1 = wval;
    if (wsel == 2) sh_b2 = wval;
    if (wsel == 3) sh_d = wval;
    frame_bits[p] = d;
    live = synced && en;
    e_b1v = live && (p == ac_b1 * 8 + 7);
    e_b2v = live && (p == ac_b2 * 8 + 7);
    e_dv  = live && (p == (ac_d / 4) * 8 + (ac_d % 4) * 2 + 1);
    if (e_b1v) e_b1 = take_byte(ac_b1);
    if (e_b2v) e_b2 = take_byte(ac_b2);
    if (e_dv)  e_d  = take_pair(ac_d);
    pos = (p + 1) % FRAME;
  endtask

  // en_mode: 0 off, 1 on, 2 random per cycle
  task automatic run(int ncyc, bit sync_first, bit sync_wrap, int en_mode, bit rnd_wr);
    for (int i = 0; i < ncyc; i++) begin
      bit fs;
      bit en;
      int ws;
      int wv;
      fs = (i == 0 && sync_first) || (sync_wrap && pos == 0);
      en = (en_mode == 1) ? 1'b1 : (en_mode == 2) ? 1'($urandom % 2) : 1'b0;
      ws = 0; wv = 0;
      if (rnd_wr && ($urandom % 40) == 0) begin
        ws = 1 + int'($urandom % 3);
        wv = (ws == 3) ? int'($urandom % 256) : int'($urandom % 64);
      end
      cycle(fs, 1'($urandom % 2), en, ws, wv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R4: outputs zero, strobes low while and right after reset
    check("reset b1_vld (R4)", int'(b1_vld), 0);
    check("reset d_vld (R4)", int'(d_vld), 0);
    check("reset b1_byte (R4)", int'(b1_byte), 0);
    check("reset d_dibit (R4)", int'(d_dibit), 0);
    rst_n = 1'b1;

    cur_req = "R8";                          // no capture before first sync
    run(FRAME + 40, 1'b0, 1'b0, 1, 1'b0);
    pos = 0;                                 // bench position follows the coming sync
    cur_req = "R4";                          // default selections 0, 1, 08h
    run(2 * FRAME, 1'b1, 1'b1, 1, 1'b0);
    cur_req = "R3";                          // write in the frame-start cycle itself
    while (pos != 0) cycle(1'b0, 1'($urandom % 2), 1'b1, 0, 0);
    cycle(1'b1, 1'b1, 1'b1, 1, 9);
    run(2 * FRAME, 1'b0, 1'b1, 1, 1'b0);
    cur_req = "R3";                          // random mid-frame writes
    run(6 * FRAME, 1'b0, 1'b1, 1, 1'b1);
    cur_req = "R9";                          // shared slot
    cycle(1'b0, 1'b0, 1'b1, 1, 5);
    cycle(1'b0, 1'b1, 1'b1, 2, 5);
    cycle(1'b0, 1'b0, 1'b1, 3, 5 * 4 + 1);
    run(2 * FRAME, 1'b0, 1'b1, 1, 1'b0);
    cur_req = "R2";                          // last slot, last sub-slot
    cycle(1'b0, 1'b1, 1'b1, 3, 63 * 4 + 3);
    cycle(1'b0, 1'b0, 1'b1, 1, 63);
    cycle(1'b0, 1'b1, 1'b1, 2, 0);
    run(2 * FRAME, 1'b0, 1'b1, 1, 1'b0);
    cur_req = "R7";                          // early sync and free wrap
    run(203, 1'b0, 1'b0, 1, 1'b0);
    run(300, 1'b1, 1'b0, 1, 1'b0);
    run(3 * FRAME, 1'b1, 1'b0, 1, 1'b1);
    cur_req = "R5";                          // format disabled, then toggling
    run(FRAME, 1'b0, 1'b1, 0, 1'b0);
    run(2 * FRAME, 1'b0, 1'b1, 2, 1'b1);
    cur_req = "R1";
    run(2 * FRAME, 1'b0, 1'b1, 1, 1'b1);
    cycle(1'b0, 1'b0, 1'b1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule